// File: doc/BRIEF.md
# SPI EEPROM Command Commit/Cancel Gate

This block is the command front end of a serial EEPROM slave on SPI mode 0. It samples the chip select, serial clock and serial data pins into the system clock domain. It counts the rising serial clock edges of each frame and captures the instruction byte. When chip select returns high, it decides whether the frame is simply dropped or whether a nonvolatile write must start.

The decision depends on the exact edge count at the moment of deselection, with a separate rule for each instruction:
- Reads and status reads never commit.
- An array write commits only on a byte boundary inside the data phase.
- A status write commits only after exactly fifteen edges.
- Write-enable and write-disable take effect from the seventh edge on.

A commit produces a one-cycle start pulse that carries the target and the byte count. It also starts a busy window of fixed length, during which the pins are not looked at.

The memory array, the serial output path, block protection and pin timing checks belong to neighbouring logic.

Top module: `eeprom_cmd_gate`

## Requirements
- R1: After reset, `busy` and `wel` are 0 and no `wr_start` pulse occurs.
- R2: A frame with instruction 0x06 that gets at least 8 edges sets `wel`. A frame with instruction 0x04 that gets at least 8 edges clears it. Bits are taken on rising `sck` edges, MSB first.
- R3: An enable or disable frame deselected after fewer than 7 edges leaves `wel` unchanged. After exactly 7 edges, the seven received bits act as the instruction with bit 0 taken as 0, so 0000011 sets `wel` and 0000010 clears it.
- R4: Frames with instruction 0x03 or 0x05 that get 8 or more edges never pulse `wr_start` and never change `wel`.
- R5: An instruction 0x02 frame carries 8 instruction bits, then 16 address bits, then data bytes. Deselection after N edges, with N at least 32 and N−24 a multiple of 8, commits. It pulses `wr_start` with `wr_status`=0 and `wr_nbytes`=(N−24)/8.
- R6: An instruction 0x02 frame deselected inside the instruction, the address, or before bit 0 of any data byte causes no `wr_start`.
- R7: An instruction 0x01 frame commits a status write (`wr_start` with `wr_status`=1) only when deselected after exactly 15 edges. Fewer edges, or 16 or more, cancel it.
- R8: A commit needs `wel`=1, and it clears `wel`. Without `wel` the frame is dropped.
- R9: After `wr_start`, `busy` is 1 for exactly WR_CYCLES clocks. While it is 1, no pin activity changes `wel` or starts a write.
- R10: When `sck` and `cs_n` rise in the same sample, the clock edge is counted before the deselection is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, asynchronous |
| si | input | 1 | Serial data in pin, asynchronous |
| wr_start | output | 1 | One-cycle pulse: nonvolatile write committed |
| wr_status | output | 1 | With `wr_start`: 1 = status register, 0 = array |
| wr_nbytes | output | $clog2(MAX_BYTES+1) | With `wr_start`: number of complete data bytes |
| busy | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |

## Verification
Each instruction is tried at every relevant cut point: just before, at, and just after its commit edge. This separates a gate that counts edges from one that only watches byte completion. Frames whose deselection coincides with the last clock edge show whether that edge is counted first. They flip the status-write result from commit to cancel at edge 16, and from cancel to commit at D0 of a data byte. Random sequences mix instruction, cut length, coincidence and latch state, so frames also meet a set or cleared latch. A frame sent inside a busy window shows whether the pins are truly ignored.

// File: rtl/eeprom_gate_pkg.sv
// Shared instruction codes and frame geometry for the EEPROM command gate.
// Assumes SPI mode 0 with MSB-first bytes.
package eeprom_gate_pkg;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam int HDR_BITS  = 24;   // instruction plus 16-bit address
    localparam int OP_BITS   = 8;
    localparam int LATCH_CUT = 7;    // edge from which enable/disable acts
    localparam int SR_CUT    = 15;   // only edge count that commits a status write
endpackage

// File: rtl/gate_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes every pin holds each level for at least three system clocks.
module gate_sync #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages per pin into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            lvl_o  <= RST_VAL;
        end else begin
            meta_q <= pin_i;
            lvl_o  <= meta_q;
        end
    end
endmodule

// File: rtl/gate_frame.sv
// Frame tracker and commit/cancel decision. It counts rising sck edges while
// selected, captures the instruction and, on deselection, decides the outcome
// from the edge count. It owns the write-enable latch.
// Assumes synchronized inputs. An sck rise in the same sample as the cs rise
// is counted first.
module gate_frame
    import eeprom_gate_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int NB_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy_i,
    input  logic            cs_n_s,
    input  logic            sck_s,
    input  logic            si_s,
    output logic            start_o,
    output logic            status_o,
    output logic [NB_W-1:0] nbytes_o,
    output logic            wel_o
);
    localparam int CNT_MAX = HDR_BITS + 8 * MAX_BYTES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             cs_q, sck_q, in_frame;
    logic [CNT_W-1:0] cnt, cnt_nx, dbits;
    logic [7:0]       op, op_nx, eff_op;
    logic             sck_rise, cs_rise, cs_fall, live, edge_now, end_now;
    logic             latch_vld, set_wel, clr_wel, arr_go, st_go;

    // Edge detection and next-count computation (clock edge before deselect).
    always_comb begin
        sck_rise = sck_s & ~sck_q;
        cs_rise  = cs_n_s & ~cs_q;
        cs_fall  = ~cs_n_s & cs_q;
        live     = in_frame & ~busy_i;
        edge_now = live & sck_rise;
        cnt_nx   = (edge_now && cnt != CNT_W'(CNT_MAX)) ? cnt + 1'b1 : cnt;
        op_nx    = (edge_now && cnt < CNT_W'(OP_BITS)) ? {op[6:0], si_s} : op;
        end_now  = live & cs_rise;
        dbits    = cnt_nx - CNT_W'(HDR_BITS);
    end

    // Outcome of a deselection, per instruction.
    always_comb begin
        eff_op    = (cnt_nx == CNT_W'(LATCH_CUT)) ? {op_nx[6:0], 1'b0} : op_nx;
        latch_vld = end_now && cnt_nx >= CNT_W'(LATCH_CUT);
        set_wel   = latch_vld && eff_op == OP_WREN;
        clr_wel   = latch_vld && eff_op == OP_WRDI;
        arr_go    = end_now && wel_o && op_nx == OP_WRITE
                    && cnt_nx >= CNT_W'(HDR_BITS + 8) && cnt_nx[2:0] == 3'd0;
        st_go     = end_now && wel_o && op_nx == OP_WRSR
                    && cnt_nx == CNT_W'(SR_CUT);
    end

    // Pin history and frame membership; no frame may open while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            sck_q    <= 1'b0;
            in_frame <= 1'b0;
        end else begin
            cs_q  <= cs_n_s;
            sck_q <= sck_s;
            if (busy_i)       in_frame <= 1'b0;
            else if (cs_fall) in_frame <= 1'b1;
            else if (cs_rise) in_frame <= 1'b0;
        end
    end

    // Edge counter and instruction shifter, cleared outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !live || cs_rise) begin
            cnt <= '0;
            op  <= '0;
        end else begin
            cnt <= cnt_nx;
            op  <= op_nx;
        end
    end

    // Write-enable latch and registered commit outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o    <= 1'b0;
            start_o  <= 1'b0;
            status_o <= 1'b0;
            nbytes_o <= '0;
        end else begin
            if (arr_go || st_go) wel_o <= 1'b0;
            else if (set_wel)    wel_o <= 1'b1;
            else if (clr_wel)    wel_o <= 1'b0;
            start_o  <= arr_go | st_go;
            status_o <= st_go;
            nbytes_o <= arr_go ? NB_W'(dbits >> 3) : '0;
        end
    end

    // R8: a commit consumes a latch that was set.
    assert_commit_eats_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!wel_o && $past(wel_o)));
endmodule

// File: rtl/gate_timer.sv
// Fixed-length write cycle timer. It raises busy for CYCLES clocks after a
// start pulse. Assumes no start arrives while busy.
module gate_timer #(
    parameter int CYCLES = 2000,
    parameter int TW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    logic [TW-1:0] left;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left <= '0;
        else if (start_i)        left <= TW'(CYCLES);
        else if (left != '0)     left <= left - 1'b1;
    end

    assign busy_o = (left != '0);

    // R9: every start opens a busy window, and busy only rises after a start.
    assert_start_opens_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/eeprom_cmd_gate.sv
// Top of the EEPROM command gate: pin synchronizer, frame decision logic and
// write cycle timer. Assumes SPI mode 0 pins that are slow against clk.
module eeprom_cmd_gate
    import eeprom_gate_pkg::*;
#(
    parameter int WR_CYCLES = 2000,
    parameter int MAX_BYTES = 64,
    parameter int NB_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            si,
    output logic            wr_start,
    output logic            wr_status,
    output logic [NB_W-1:0] wr_nbytes,
    output logic            busy,
    output logic            wel
);
    logic [2:0] pins_s;

    gate_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({cs_n, sck, si}),
        .lvl_o (pins_s)
    );

    gate_frame #(.MAX_BYTES(MAX_BYTES), .NB_W(NB_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy),
        .cs_n_s   (pins_s[2]),
        .sck_s    (pins_s[1]),
        .si_s     (pins_s[0]),
        .start_o  (wr_start),
        .status_o (wr_status),
        .nbytes_o (wr_nbytes),
        .wel_o    (wel)
    );

    gate_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_start),
        .busy_o  (busy)
    );

    // R9: the latch is frozen and no write starts during a write cycle.
    assert_wel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wel));
    assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> !busy);
endmodule

// File: tb/eeprom_cmd_gate_tb.sv
module eeprom_cmd_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR   = 200;
    localparam int MAXB = 64;
    localparam int NBW  = $clog2(MAXB + 1);
    localparam int H    = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic wr_start, wr_status, busy, wel;
    logic [NBW-1:0] wr_nbytes;

    int checks = 0, errors = 0, starts = 0, last_nb = 0, blen = 0;
    bit last_st = 0, exp_wel = 0, done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_cmd_gate #(.WR_CYCLES(WR), .MAX_BYTES(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wr_start(wr_start), .wr_status(wr_status), .wr_nbytes(wr_nbytes),
        .busy(busy), .wel(wel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Output monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_start) begin
            starts++;
            last_st = wr_status;
            last_nb = int'(wr_nbytes);
        end
        if (rst_n && busy) blen++;
        else if (blen != 0) begin
            check("R9 busy length", blen, WR);
            blen = 0;
        end
    end

    // Reference model of a frame's outcome, written from the requirements.
    task automatic model(input logic [7:0] op, input int n, input bit w,
                         output bit st, output bit stat, output int nb, output bit nw);
        logic [7:0] eff;
        st = 0; stat = 0; nb = 0; nw = w;
        eff = (n == 7) ? {op[7:1], 1'b0} : op;
        if (n >= 7 && eff == 8'h06) nw = 1;
        if (n >= 7 && eff == 8'h04) nw = 0;
        if (op == 8'h02 && n >= 32 && (n - 24) % 8 == 0 && w) begin
            st = 1; nb = (n - 24) / 8; nw = 0;
        end
        if (op == 8'h01 && n == 15 && w) begin
            st = 1; stat = 1; nw = 0;
        end
    endtask

    task automatic send_frame(input logic [7:0] op, input int n, input bit simul);
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            si = (i < 8) ? op[7 - i] : 1'($urandom);
            repeat (H) @(negedge clk);
            sck = 1'b1;
            if (simul && i == n - 1) cs_n = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        if (!simul) begin
            repeat (H) @(negedge clk);
            cs_n = 1'b1;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic run(input string req, input logic [7:0] op, input int n, input bit simul);
        bit st, stat, nw;
        int nb, s0;
        model(op, n, exp_wel, st, stat, nb, nw);
        s0 = starts;
        send_frame(op, n, simul);
        check({req, " starts"}, starts - s0, int'(st));
        check({req, " wel"}, int'(wel), int'(nw));
        if (st) begin
            check({req, " target"}, int'(last_st), int'(stat));
            check({req, " bytes"}, last_nb, nb);
            repeat (WR + 10) @(negedge clk);
            check("R9 busy end", int'(busy), 0);
        end
        exp_wel = nw;
    endtask

    initial begin
        int s0;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 wel", int'(wel), 0);
        check("R1 start", starts, 0);

        run("R2 wren", 8'h06, 8, 0);
        run("R2 wrdi", 8'h04, 8, 0);
        run("R3 wren cut6", 8'h06, 6, 0);
        run("R3 wren cut7", 8'h06, 7, 0);
        run("R3 wrdi cut7", 8'h04, 7, 0);
        run("R2 wren", 8'h06, 8, 0);
        run("R4 read", 8'h03, 40, 0);
        run("R4 rdsr", 8'h05, 16, 0);
        run("R2 wrdi", 8'h04, 8, 0);
        run("R8 no wel", 8'h02, 32, 0);
        run("R2 wren", 8'h06, 8, 0);
        run("R6 addr cut", 8'h02, 20, 0);
        run("R6 d1 cut", 8'h02, 31, 0);
        run("R6 page tail", 8'h02, 47, 0);
        run("R5 one byte", 8'h02, 32, 0);
        run("R8 wel after", 8'h06, 8, 0);
        run("R10 write d0", 8'h02, 48, 1);
        run("R2 wren", 8'h06, 8, 0);
        run("R7 sr cut14", 8'h01, 14, 0);
        run("R7 sr 16", 8'h01, 16, 0);
        run("R10 sr 16", 8'h01, 16, 1);
        run("R7 sr 15", 8'h01, 15, 0);
        run("R2 wren", 8'h06, 8, 0);
        run("R10 sr 15", 8'h01, 15, 1);

        // R9: frames sent during a write cycle are ignored.
        run("R2 wren", 8'h06, 8, 0);
        s0 = starts;
        send_frame(8'h02, 32, 0);
        send_frame(8'h06, 8, 0);
        repeat (WR + 10) @(negedge clk);
        check("R9 ignored wren", int'(wel), 0);
        check("R9 one start", starts - s0, 1);
        exp_wel = 0;

        // Constrained random frames (R2-R8, R10).
        for (int k = 0; k < 40; k++) begin
            logic [7:0] op;
            int n, pick;
            pick = int'($urandom_range(5));
            case (pick)
                0: op = 8'h06; 1: op = 8'h04; 2: op = 8'h05;
                3: op = 8'h03; 4: op = 8'h02; default: op = 8'h01;
            endcase
            if (op == 8'h02)
                n = ($urandom_range(1) != 0) ? 24 + 8 * int'($urandom_range(3, 1))
                                             : int'($urandom_range(50, 1));
            else if (op == 8'h01)
                n = ($urandom_range(1) != 0) ? 15 : int'($urandom_range(18, 1));
            else
                n = int'($urandom_range(20, 1));
            run("R5 random", op, n, 1'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule